// File: doc/BRIEF.md
# DMA Transfer Request Controller

This block decides, for one DMA channel, when a transfer may begin and how many transfers follow from one request. The request comes from one of three sources. In auto mode the channel makes its own requests. In external mode the request comes from an active-low input pin. In USB mode it comes from two request lines, one per endpoint of an on-chip USB function. The block issues start pulses to a transfer engine, either one pulse per single transfer or one pulse for a whole burst. It then waits for the engine's done strobe before it accepts anything new.

For the external pin, a configuration bit chooses low-level or falling-edge detection. The pin is synchronised with two flops before detection. In block mode, one external request launches a programmed number of back-to-back transfers, and an optional acknowledge pulse tells the requesting device when its request was taken. Some pairings of request source and bus mode are illegal. The block detects these, raises an error flag and refuses every request until the configuration is made legal again.

Top module: `dma_req_ctrl`

## Requirements
- R1: While `chanEnable` is 0, no start pulse is issued for any request source, even if a request is present. A request that is already present is accepted in the first cycle after `chanEnable` rises.
- R2: With `reqSource` = 0 (auto), the channel requests by itself. One clock edge after `chanEnable` rises, it pulses `xferStart` when `busMode` = 0 (cycle steal), or `burstStart` when `busMode` = 1 (burst). `xferStart` and `burstStart` are never high together.
- R3: The following settings are illegal: `reqSource` = 3; `busMode` = 3; auto with `busMode` = 2 (block); USB with any `busMode` other than 0; USB with `singleAddr` = 1. When an illegal setting is present with `chanEnable` = 1, `cfgError` rises on the next edge and no start is issued. `cfgError` clears one edge after the setting becomes legal, and acceptance resumes one edge after that.
- R4: With `reqSource` = 1 (external), `senseEdge` = 0 and `busMode` = 0, driving `reqPinN` low gives an `xferStart` pulse at the third clock edge after the change (two synchroniser flops, then the start register).
- R5: With `senseEdge` = 1, each falling edge of `reqPinN` is one request, and a pin held low is not a new request. A falling edge seen while a transfer is outstanding is held pending. It is served one edge after the engine leaves the busy state.
- R6: With `senseEdge` = 0, a pin still low when `xferDone` arrives gives the next start at the second edge after the done edge. No start is issued before the done strobe.
- R7: When `ackEnable` = 1, `ackOut` is high for exactly one cycle, together with the first start pulse of an accepted external request. It is never high for auto or USB requests, and never high when `ackEnable` = 0.
- R8: With external source and `busMode` = 2 (block), one request yields `blockSize` start pulses, with `blockSize` = 0 treated as 1. After the first, each pulse follows one edge after a `xferDone`, and `ackOut` pulses only with the first. The done after the last transfer returns the block to idle.
- R9: With `reqSource` = 2 (USB), `usbReq[0]` (endpoint 1) has priority over `usbReq[1]` (endpoint 2). The accepted start pulses `usbRdEp1` (read endpoint 1) or `usbWrEp2` (write endpoint 2) in the same cycle, and never both.
- R10: Only one transfer is outstanding at a time. `busy` is high from the start pulse until the final `xferDone`, no new request is accepted meanwhile, and all outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanEnable | input | 1 | Channel enable; gates all request acceptance |
| reqSource | input | 2 | 0 auto, 1 external pin, 2 USB, 3 reserved |
| busMode | input | 2 | 0 cycle steal, 1 burst, 2 block, 3 reserved |
| singleAddr | input | 1 | Single-address transfer selected |
| senseEdge | input | 1 | Pin detection: 0 low level, 1 falling edge |
| ackEnable | input | 1 | Enables the acknowledge pulse |
| blockSize | input | CNT_W | Transfers per block request (0 acts as 1) |
| reqPinN | input | 1 | External request pin, active low, asynchronous |
| usbReq | input | 2 | USB requests: bit 0 endpoint 1, bit 1 endpoint 2 |
| xferDone | input | 1 | Transfer engine completion strobe |
| xferStart | output | 1 | One-cycle start of a single transfer |
| burstStart | output | 1 | One-cycle start of a burst |
| ackOut | output | 1 | One-cycle request acknowledge |
| usbRdEp1 | output | 1 | Start qualifier: read from endpoint 1 |
| usbWrEp2 | output | 1 | Start qualifier: write to endpoint 2 |
| busy | output | 1 | A transfer or block is outstanding |
| cfgError | output | 1 | Illegal source and mode pairing detected |

## Verification
The bench counts the latency through the synchroniser. A design that skips a flop or adds one would move the first start by one cycle. It holds the pin low across a done strobe in both sense modes. Edge sensing that retriggers on a held level would issue extra transfers, and level sensing that samples too early would start a transfer before the done. It sends a falling edge while the channel is busy, which catches a pending latch that is lost or served too early. It walks each illegal source and mode pairing, counts the transfers in a block, including a block size of zero, and checks where the acknowledge pulses appear. A wrong block counter gives one transfer too many or too few, and a loose acknowledge fires for every transfer in a block.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [1:0] {
    SRC_AUTO = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_USB  = 2'd2,
    SRC_RSVD = 2'd3
  } reqSrcE;

  typedef enum logic [1:0] {
    MODE_STEAL = 2'd0,
    MODE_BURST = 2'd1,
    MODE_BLOCK = 2'd2,
    MODE_RSVD  = 2'd3
  } busModeE;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctlStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPending;
    logic loadCount;
    logic decCount;
  } ctlStrobeS;

endpackage

// File: rtl/dma_req_dp.sv
module dma_req_dp
  import dma_req_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEnable,
  input  logic             senseEdge,
  input  logic             reqPinN,
  input  logic [CNT_W-1:0] blockSize,
  input  ctlStrobeS        strb,
  output logic             reqLevel,
  output logic             reqEdge,
  output logic             countLast
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_N-1:0] syncQ;
  logic              prevQ;
  logic              pendQ;
  logic              fallNow;
  logic [CNT_W-1:0]  countQ;

  // synchroniser chain, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_N-2:0], reqPinN};
      prevQ <= syncQ[SYNC_N-1];
    end
  end

  assign fallNow  = prevQ & ~syncQ[SYNC_N-1];
  assign reqLevel = ~syncQ[SYNC_N-1];
  assign reqEdge  = pendQ | fallNow;

  // pending falling edge, kept only while edge sensing is armed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (!(chanEnable && senseEdge)) begin
      pendQ <= 1'b0;
    end else begin
      pendQ <= (pendQ | fallNow) & ~strb.clrPending;
    end
  end

  // block transfer counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.loadCount) begin
      countQ <= (blockSize == '0) ? ONE : blockSize;
    end else if (strb.decCount && countQ != '0) begin
      countQ <= countQ - ONE;
    end
  end

  assign countLast = (countQ <= ONE);

endmodule

// File: rtl/dma_req_ctl.sv
module dma_req_ctl
  import dma_req_pkg::*;
#(
  parameter int unsigned EP_N = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            chanEnable,
  input  logic [1:0]      reqSource,
  input  logic [1:0]      busMode,
  input  logic            singleAddr,
  input  logic            senseEdge,
  input  logic            ackEnable,
  input  logic [EP_N-1:0] usbReq,
  input  logic            xferDone,
  input  logic            reqLevel,
  input  logic            reqEdge,
  input  logic            countLast,
  output ctlStrobeS       strb,
  output logic            xferStart,
  output logic            burstStart,
  output logic            ackOut,
  output logic            usbRdEp1,
  output logic            usbWrEp2,
  output logic            busy,
  output logic            cfgError
);

  reqSrcE   src;
  busModeE  mode;
  ctlStateE stateQ;
  logic     illegal, reqAvail, accept, doneInWait;
  logic     blockQ, errQ;
  logic     startQ, burstQ, ackQ, ep1Q, ep2Q;

  assign src  = reqSrcE'(reqSource);
  assign mode = busModeE'(busMode);

  always_comb begin
    illegal = (src == SRC_RSVD) || (mode == MODE_RSVD)
           || (src == SRC_AUTO && mode == MODE_BLOCK)
           || (src == SRC_USB && (mode != MODE_STEAL || singleAddr));
    unique case (src)
      SRC_AUTO: reqAvail = 1'b1;
      SRC_EXT:  reqAvail = senseEdge ? reqEdge : reqLevel;
      SRC_USB:  reqAvail = |usbReq;
      default:  reqAvail = 1'b0;
    endcase
    accept     = (stateQ == ST_IDLE) && chanEnable && !illegal && !errQ && reqAvail;
    doneInWait = (stateQ == ST_WAIT) && xferDone;
    strb.clrPending = accept && (src == SRC_EXT);
    strb.loadCount  = accept && (mode == MODE_BLOCK);
    strb.decCount   = doneInWait && blockQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      blockQ <= 1'b0;
      startQ <= 1'b0;
      burstQ <= 1'b0;
      ackQ   <= 1'b0;
      ep1Q   <= 1'b0;
      ep2Q   <= 1'b0;
    end else begin
      startQ <= 1'b0;
      burstQ <= 1'b0;
      ackQ   <= 1'b0;
      ep1Q   <= 1'b0;
      ep2Q   <= 1'b0;
      if (accept) begin
        stateQ <= ST_WAIT;
        blockQ <= (mode == MODE_BLOCK);
        if (mode == MODE_BURST) burstQ <= 1'b1;
        else                    startQ <= 1'b1;
        ackQ <= ackEnable && (src == SRC_EXT);
        ep1Q <= (src == SRC_USB) && usbReq[0];
        ep2Q <= (src == SRC_USB) && !usbReq[0] && usbReq[1];
      end else if (doneInWait) begin
        if (blockQ && !countLast) begin
          startQ <= 1'b1;
        end else begin
          stateQ <= ST_IDLE;
          blockQ <= 1'b0;
        end
      end
    end
  end

  // sticky configuration error, released by a legal setting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       errQ <= 1'b0;
    else if (chanEnable && illegal)  errQ <= 1'b1;
    else if (!illegal)               errQ <= 1'b0;
  end

  assign xferStart  = startQ;
  assign burstStart = burstQ;
  assign ackOut     = ackQ;
  assign usbRdEp1   = ep1Q;
  assign usbWrEp2   = ep2Q;
  assign busy       = (stateQ == ST_WAIT);
  assign cfgError   = errQ;

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEnable,
  input  logic [1:0]       reqSource,
  input  logic [1:0]       busMode,
  input  logic             singleAddr,
  input  logic             senseEdge,
  input  logic             ackEnable,
  input  logic [CNT_W-1:0] blockSize,
  input  logic             reqPinN,
  input  logic [1:0]       usbReq,
  input  logic             xferDone,
  output logic             xferStart,
  output logic             burstStart,
  output logic             ackOut,
  output logic             usbRdEp1,
  output logic             usbWrEp2,
  output logic             busy,
  output logic             cfgError
);

  ctlStrobeS strb;
  logic      reqLevel, reqEdge, countLast;

  dma_req_dp #(.CNT_W(CNT_W), .SYNC_N(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .chanEnable (chanEnable),
    .senseEdge  (senseEdge),
    .reqPinN    (reqPinN),
    .blockSize  (blockSize),
    .strb       (strb),
    .reqLevel   (reqLevel),
    .reqEdge    (reqEdge),
    .countLast  (countLast)
  );

  dma_req_ctl #(.EP_N(2)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .chanEnable (chanEnable),
    .reqSource  (reqSource),
    .busMode    (busMode),
    .singleAddr (singleAddr),
    .senseEdge  (senseEdge),
    .ackEnable  (ackEnable),
    .usbReq     (usbReq),
    .xferDone   (xferDone),
    .reqLevel   (reqLevel),
    .reqEdge    (reqEdge),
    .countLast  (countLast),
    .strb       (strb),
    .xferStart  (xferStart),
    .burstStart (burstStart),
    .ackOut     (ackOut),
    .usbRdEp1   (usbRdEp1),
    .usbWrEp2   (usbWrEp2),
    .busy       (busy),
    .cfgError   (cfgError)
  );

endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic chanEnable,
  input logic xferDone,
  input logic xferStart,
  input logic burstStart,
  input logic ackOut,
  input logic usbRdEp1,
  input logic usbWrEp2,
  input logic busy,
  input logic cfgError
);

  AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(xferStart && burstStart)); // R2

  AST_NO_START_ON_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !(xferStart || burstStart)); // R3

  AST_NEW_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    ((xferStart || burstStart) && !$past(busy)) |-> $past(chanEnable)); // R1

  AST_ACK_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> (xferStart || burstStart)); // R7

  AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut); // R7

  AST_EP_QUALIFIER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({usbRdEp1, usbWrEp2}) && ((usbRdEp1 || usbWrEp2) -> xferStart)); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart || burstStart) |-> (!$past(busy) || $past(xferDone))); // R10

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart || burstStart) |-> busy); // R10

endmodule

bind dma_req_ctrl dma_req_ctrl_chk u_chk (.*);

// File: tb/tb_dma_req_ctrl.sv
module tb_dma_req_ctrl;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic             chanEnable;
  logic [1:0]       reqSource;
  logic [1:0]       busMode;
  logic             singleAddr;
  logic             senseEdge;
  logic             ackEnable;
  logic [CNT_W-1:0] blockSize;
  logic             reqPinN;
  logic [1:0]       usbReq;
  logic             xferDone;
  logic             xferStart, burstStart, ackOut, usbRdEp1, usbWrEp2, busy, cfgError;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_req_ctrl #(.CNT_W(CNT_W)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; chanEnable = 1'b0; reqSource = 2'd0; busMode = 2'd0;
    singleAddr = 1'b0; senseEdge = 1'b0; ackEnable = 1'b0; blockSize = '0;
    reqPinN = 1'b1; usbReq = 2'b00; xferDone = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic pulseDone();
    xferDone = 1'b1;
    tick(1);
    xferDone = 1'b0;
  endtask

  task automatic testResetState();
    doReset();
    check({xferStart, burstStart, ackOut, usbRdEp1, usbWrEp2, busy, cfgError} == 7'b0,
          "R10 reset outputs", {xferStart, burstStart, ackOut, usbRdEp1, usbWrEp2, busy, cfgError}, 0);
  endtask

  task automatic testDisabled();
    int starts = 0;
    doReset();
    reqSource = 2'd1; reqPinN = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(1); starts += xferStart + burstStart; end
    reqSource = 2'd2; usbReq = 2'b11;
    for (int i = 0; i < 4; i++) begin tick(1); starts += xferStart + burstStart; end
    reqSource = 2'd0;
    for (int i = 0; i < 4; i++) begin tick(1); starts += xferStart + burstStart; end
    check(starts == 0, "R1 no start while disabled", starts, 0);
    reqSource = 2'd1; usbReq = 2'b00; chanEnable = 1'b1;
    tick(1);
    check(xferStart == 1'b1, "R1 start after enable", xferStart, 1);
  endtask

  task automatic testAuto();
    doReset();
    ackEnable = 1'b1;
    tick(1);
    chanEnable = 1'b1;
    tick(1);
    check(xferStart && !burstStart, "R2 auto cycle-steal start", {xferStart, burstStart}, 2);
    check(ackOut == 1'b0, "R7 no ack for auto", ackOut, 0);
    tick(1);
    check(!xferStart && busy, "R10 busy after auto start", {xferStart, busy}, 1);
    doReset();
    busMode = 2'd1;
    tick(1);
    chanEnable = 1'b1;
    tick(1);
    check(burstStart && !xferStart, "R2 auto burst start", {xferStart, burstStart}, 1);
  endtask

  task automatic expectError(input logic [1:0] s, input logic [1:0] m, input logic sa, input string tag);
    doReset();
    reqSource = s; busMode = m; singleAddr = sa; usbReq = 2'b11; reqPinN = 1'b0;
    chanEnable = 1'b1;
    tick(1);
    check(cfgError && !xferStart && !burstStart, tag, {cfgError, xferStart, burstStart}, 4);
  endtask

  task automatic testIllegal();
    int starts = 0;
    expectError(2'd0, 2'd2, 1'b0, "R3 auto block");
    expectError(2'd2, 2'd1, 1'b0, "R3 usb burst");
    expectError(2'd2, 2'd2, 1'b0, "R3 usb block");
    expectError(2'd2, 2'd0, 1'b1, "R3 usb single address");
    expectError(2'd3, 2'd0, 1'b0, "R3 reserved source");
    expectError(2'd1, 2'd3, 1'b0, "R3 reserved mode");
    doReset();
    busMode = 2'd2; chanEnable = 1'b1;
    for (int i = 0; i < 4; i++) begin tick(1); starts += xferStart + burstStart; end
    check(starts == 0 && cfgError, "R3 blocked while illegal", starts, 0);
    busMode = 2'd0;
    tick(1);
    check(!cfgError && !xferStart, "R3 error clears", {cfgError, xferStart}, 0);
    tick(1);
    check(xferStart == 1'b1, "R3 acceptance resumes", xferStart, 1);
  endtask

  task automatic testLevel();
    int starts = 0;
    doReset();
    reqSource = 2'd1; ackEnable = 1'b1; chanEnable = 1'b1;
    tick(2);
    reqPinN = 1'b0;
    tick(1); starts += xferStart;
    tick(1); starts += xferStart;
    check(starts == 0, "R4 no start before sync", starts, 0);
    tick(1);
    check(xferStart == 1'b1, "R4 level start at third edge", xferStart, 1);
    check(ackOut == 1'b1, "R7 ack with external start", ackOut, 1);
    tick(1);
    check(ackOut == 1'b0, "R7 ack one cycle", ackOut, 0);
    starts = 0;
    for (int i = 0; i < 4; i++) begin tick(1); starts += xferStart; end
    check(starts == 0, "R6 no start before done", starts, 0);
    pulseDone();
    check(xferStart == 1'b0, "R6 not at done edge", xferStart, 0);
    tick(1);
    check(xferStart == 1'b1, "R6 restart second edge after done", xferStart, 1);
    reqPinN = 1'b1;
    tick(4);
    pulseDone();
    starts = 0;
    for (int i = 0; i < 4; i++) begin tick(1); starts += xferStart; end
    check(starts == 0 && !busy, "R6 released pin idles", starts, 0);
  endtask

  task automatic testEdge();
    int starts = 0;
    doReset();
    reqSource = 2'd1; senseEdge = 1'b1; chanEnable = 1'b1;
    tick(2);
    reqPinN = 1'b0;
    tick(3);
    check(xferStart == 1'b1, "R5 falling edge start", xferStart, 1);
    check(ackOut == 1'b0, "R7 no ack when disabled", ackOut, 0);
    pulseDone();
    for (int i = 0; i < 4; i++) begin tick(1); starts += xferStart; end
    check(starts == 0, "R5 held low no retrigger", starts, 0);
    reqPinN = 1'b1; tick(3);
    reqPinN = 1'b0; tick(3);
    check(xferStart == 1'b1, "R5 second edge start", xferStart, 1);
    reqPinN = 1'b1; tick(3);
    reqPinN = 1'b0;
    starts = 0;
    for (int i = 0; i < 5; i++) begin tick(1); starts += xferStart; end
    check(starts == 0, "R5 edge while busy waits", starts, 0);
    pulseDone();
    check(xferStart == 1'b0, "R5 pending not at done edge", xferStart, 0);
    tick(1);
    check(xferStart == 1'b1, "R5 pending served", xferStart, 1);
  endtask

  task automatic testBlock();
    int acks = 0;
    doReset();
    reqSource = 2'd1; busMode = 2'd2; senseEdge = 1'b1; ackEnable = 1'b1;
    blockSize = 8'd3; chanEnable = 1'b1;
    tick(2);
    reqPinN = 1'b0;
    tick(3);
    check(xferStart && ackOut, "R8 first block start with ack", {xferStart, ackOut}, 3);
    pulseDone();
    check(xferStart == 1'b1, "R8 second transfer", xferStart, 1);
    acks += ackOut;
    tick(2);
    pulseDone();
    check(xferStart == 1'b1, "R8 third transfer", xferStart, 1);
    acks += ackOut;
    check(acks == 0, "R8 ack once per block", acks, 0);
    tick(2);
    pulseDone();
    check(!xferStart && !busy, "R8 block ends after count", {xferStart, busy}, 0);
    doReset();
    reqSource = 2'd1; busMode = 2'd2; senseEdge = 1'b1; blockSize = '0; chanEnable = 1'b1;
    tick(2);
    reqPinN = 1'b0;
    tick(3);
    check(xferStart == 1'b1, "R8 zero size start", xferStart, 1);
    pulseDone();
    check(!xferStart && !busy, "R8 zero size acts as one", {xferStart, busy}, 0);
  endtask

  task automatic testUsb();
    doReset();
    reqSource = 2'd2; ackEnable = 1'b1; usbReq = 2'b11; chanEnable = 1'b1;
    tick(1);
    check(xferStart && usbRdEp1 && !usbWrEp2, "R9 endpoint 1 priority",
          {xferStart, usbRdEp1, usbWrEp2}, 6);
    check(ackOut == 1'b0, "R7 no ack for usb", ackOut, 0);
    usbReq = 2'b10;
    tick(1);
    pulseDone();
    check(xferStart == 1'b0, "R10 idle edge after done", xferStart, 0);
    tick(1);
    check(xferStart && usbWrEp2 && !usbRdEp1, "R9 endpoint 2 write",
          {xferStart, usbRdEp1, usbWrEp2}, 5);
  endtask

  initial begin
    testResetState();
    testDisabled();
    testAuto();
    testIllegal();
    testLevel();
    testEdge();
    testBlock();
    testUsb();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule